// File: doc/BRIEF.md
# Per-Thread Reorder Buffer Share Allocator

This block sits next to the storage of a reorder buffer that several hardware threads share. From a sharing mode, the total number of entries, a threshold value and a mask of the threads that are running, it works out how many entries each thread may hold at most. It registers those per-thread ceilings, so they follow the inputs one clock later.

Using the registered ceilings and the live per-thread occupancy counts, it also reports how many entries each thread may still claim. It reports how many entries are still unused in the whole buffer as well. Dispatch logic uses these numbers to decide whether a thread may allocate another entry this cycle.

Three sharing modes exist. In the first, every thread may fill the whole buffer. In the second, the buffer is split evenly among the running threads. In the third, each thread is capped at a programmable threshold, and a lone running thread gets the whole buffer. A fourth encoding is not a valid mode: it raises an error flag and forces every ceiling to zero.

Top module: `rob_share_alloc`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every ceiling on `limit_o` is zero and `mode_err_o` is low.
- R2: With `mode_i` = 0 (shared), every thread's ceiling equals `total_i`.
- R3: With `mode_i` = 1 (split) and all threads active, every ceiling is `total_i` divided by NT, rounded down with the remainder dropped.
- R4: With `mode_i` = 1 and some but not all threads active, each active thread's ceiling is `total_i` divided by the number of set bits in `active_i`, rounded down. Each inactive thread's ceiling is `total_i` divided by NT.
- R5: With `mode_i` = 1 and `active_i` all zero, every ceiling is `total_i` divided by NT.
- R6: With `mode_i` = 2 (capped) and a number of active threads other than one, every ceiling equals `thresh_i`.
- R7: With `mode_i` = 2 and exactly one bit of `active_i` set, that thread's ceiling equals `total_i`. Every other thread's ceiling equals `thresh_i`.
- R8: With `mode_i` = 3, `mode_err_o` is high and every ceiling is zero.
- R9: The ceilings and `mode_err_o` follow the inputs sampled at the previous rising clock edge, and keep their value until the next edge.
- R10: Thread t's field of `free_o` equals its current ceiling minus its `occ_i` field. It is zero when the occupancy is at or above the ceiling.
- R11: `total_free_o` equals `total_i` minus the sum of all `occ_i` fields. It is zero when the sum reaches or exceeds `total_i`.
- R12: Thread t uses bits [t*CW +: CW] of `occ_i`, `limit_o` and `free_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Sharing mode: 0 shared, 1 split, 2 capped, 3 invalid |
| total_i | input | CW | Total reorder buffer entries |
| thresh_i | input | CW | Per-thread cap used in capped mode |
| active_i | input | NT | One bit per running thread |
| occ_i | input | NT*CW | Per-thread occupancy, thread t at [t*CW +: CW] |
| limit_o | output | NT*CW | Registered per-thread ceilings |
| free_o | output | NT*CW | Per-thread entries still claimable |
| total_free_o | output | CW | Unused entries in the whole buffer |
| mode_err_o | output | 1 | Registered flag for the invalid mode encoding |

## Verification
The bench targets totals that do not divide evenly by the active count. A design that rounded up, or divided by NT instead of the active count, would hand out more entries than exist, or fewer than it should. It drives the lone-thread case of capped mode, where a design that missed the special case would keep that thread at the threshold. It also drives the empty mask in split mode, where a design without a guard would divide by zero.

Occupancies above a ceiling that has just been lowered, and occupancy sums above the total, would wrap around to huge free counts if the subtraction did not stop at zero. A check taken just before a clock edge catches ceilings that react to the inputs without the register stage.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
    typedef enum logic [1:0] {
        SHARE_ALL   = 2'd0,
        SHARE_SPLIT = 2'd1,
        SHARE_CAP   = 2'd2,
        SHARE_BAD   = 2'd3
    } share_mode_e;
endpackage

// File: rtl/rsa_active_count.sv
module rsa_active_count #(
    parameter int NT = 4,
    localparam int NW = $clog2(NT + 1)
) (
    input  logic [NT-1:0] mask_i,
    output logic [NW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < NT; i++) begin
            count_o = count_o + NW'(mask_i[i]);
        end
    end
endmodule

// File: rtl/rsa_quot_table.sv
// Quotients of the total by every divisor 1..NT, each a constant-divisor
// divide, then selected by the live active count.
module rsa_quot_table #(
    parameter int NT = 4,
    parameter int CW = 8,
    localparam int NW = $clog2(NT + 1)
) (
    input  logic [CW-1:0] total_i,
    input  logic [NW-1:0] count_i,
    output logic [CW-1:0] share_o,
    output logic [CW-1:0] base_o
);
    logic [CW-1:0] quot [NT];

    for (genvar k = 0; k < NT; k++) begin : g_div
        assign quot[k] = total_i / CW'(k + 1);
    end

    assign base_o = quot[NT-1];

    always_comb begin
        share_o = quot[NT-1];
        for (int k = 0; k < NT; k++) begin
            if (count_i == NW'(k + 1)) share_o = quot[k];
        end
    end
endmodule

// File: rtl/rsa_free_calc.sv
module rsa_free_calc #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] limit_i,
    input  logic [CW-1:0] occ_i,
    output logic [CW-1:0] free_o
);
    always_comb begin
        if (occ_i >= limit_i) free_o = '0;
        else                  free_o = limit_i - occ_i;
    end
endmodule

// File: rtl/rob_share_alloc.sv
module rob_share_alloc #(
    parameter int NT = 4,
    parameter int CW = 8,
    localparam int NW = $clog2(NT + 1),
    localparam int SW = CW + $clog2(NT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CW-1:0]    total_i,
    input  logic [CW-1:0]    thresh_i,
    input  logic [NT-1:0]    active_i,
    input  logic [NT*CW-1:0] occ_i,
    output logic [NT*CW-1:0] limit_o,
    output logic [NT*CW-1:0] free_o,
    output logic [CW-1:0]    total_free_o,
    output logic             mode_err_o
);
    import rsa_pkg::*;

    typedef struct packed {
        logic [NT-1:0][CW-1:0] lim;
        logic                  err;
    } state_t;

    state_t        st_d, st_q;
    logic [NW-1:0] n_act;
    logic [CW-1:0] q_share, q_base;
    share_mode_e   mode;

    assign mode = share_mode_e'(mode_i);

    rsa_active_count #(.NT(NT)) u_cnt (
        .mask_i  (active_i),
        .count_o (n_act)
    );

    rsa_quot_table #(.NT(NT), .CW(CW)) u_quot (
        .total_i (total_i),
        .count_i (n_act),
        .share_o (q_share),
        .base_o  (q_base)
    );

    always_comb begin
        st_d = st_q;
        st_d.err = 1'b0;
        for (int t = 0; t < NT; t++) begin
            unique case (mode)
                SHARE_ALL:   st_d.lim[t] = total_i;
                SHARE_SPLIT: st_d.lim[t] = active_i[t] ? q_share : q_base;
                SHARE_CAP:   st_d.lim[t] = (n_act == NW'(1) && active_i[t])
                                           ? total_i : thresh_i;
                default:     st_d.lim[t] = '0;
            endcase
        end
        if (mode == SHARE_BAD) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign limit_o[t*CW +: CW] = st_q.lim[t];
        rsa_free_calc #(.CW(CW)) u_free (
            .limit_i (st_q.lim[t]),
            .occ_i   (occ_i[t*CW +: CW]),
            .free_o  (free_o[t*CW +: CW])
        );
    end

    logic [SW-1:0] occ_sum;
    always_comb begin
        occ_sum = '0;
        for (int t = 0; t < NT; t++) begin
            occ_sum = occ_sum + SW'(occ_i[t*CW +: CW]);
        end
        if (occ_sum >= SW'(total_i)) total_free_o = '0;
        else                         total_free_o = total_i - occ_sum[CW-1:0];
    end

    assign mode_err_o = st_q.err;
endmodule

// File: rtl/rsa_share_chk.sv
module rsa_share_chk #(
    parameter int NT = 4,
    parameter int CW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [CW-1:0]    total_i,
    input logic [CW-1:0]    thresh_i,
    input logic [NT-1:0]    active_i,
    input logic [NT*CW-1:0] occ_i,
    input logic [NT*CW-1:0] limit_o,
    input logic [NT*CW-1:0] free_o,
    input logic [CW-1:0]    total_free_o,
    input logic             mode_err_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (limit_o == '0 && !mode_err_o));

    // R8
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3) |=> (mode_err_o && limit_o == '0));

    // R2
    shared_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> (limit_o == {NT{$past(total_i)}} && !mode_err_o));

    // R6
    cap_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && $countones(active_i) != 1)
        |=> (limit_o == {NT{$past(thresh_i)}}));

    // R11
    total_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_free_o <= total_i);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        // R10
        free_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_i[t*CW +: CW] >= limit_o[t*CW +: CW]) |-> (free_o[t*CW +: CW] == '0));
        // R10
        free_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_i[t*CW +: CW] < limit_o[t*CW +: CW])
            |-> ({1'b0, free_o[t*CW +: CW]} + {1'b0, occ_i[t*CW +: CW]}
                 == {1'b0, limit_o[t*CW +: CW]}));
    end
endmodule

bind rob_share_alloc rsa_share_chk #(.NT(NT), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .total_i      (total_i),
    .thresh_i     (thresh_i),
    .active_i     (active_i),
    .occ_i        (occ_i),
    .limit_o      (limit_o),
    .free_o       (free_o),
    .total_free_o (total_free_o),
    .mode_err_o   (mode_err_o)
);

// File: tb/test_rob_share_alloc.sv
`timescale 1ns/1ps
module test_rob_share_alloc;
    localparam int NT = 4;
    localparam int CW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = '0;
    logic [CW-1:0]    total_i = '0;
    logic [CW-1:0]    thresh_i = '0;
    logic [NT-1:0]    active_i = '0;
    logic [NT*CW-1:0] occ_i = '0;
    logic [NT*CW-1:0] limit_o, free_o;
    logic [CW-1:0]    total_free_o;
    logic             mode_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rob_share_alloc #(.NT(NT), .CW(CW)) i_rob_share_alloc (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .total_i(total_i),
        .thresh_i(thresh_i), .active_i(active_i), .occ_i(occ_i),
        .limit_o(limit_o), .free_o(free_o), .total_free_o(total_free_o),
        .mode_err_o(mode_err_o)
    );

    function automatic int act_count(logic [NT-1:0] a);
        int n = 0;
        for (int i = 0; i < NT; i++) n += int'(a[i]);
        return n;
    endfunction

    function automatic int exp_lim(logic [1:0] m, int tot, int thr, logic [NT-1:0] a, int t);
        int n = act_count(a);
        case (m)
            2'd0: return tot;
            2'd1: return a[t] ? tot / n : tot / NT;
            2'd2: return (n == 1 && a[t]) ? tot : thr;
            default: return 0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every output against values computed from the inputs that
    // were applied before the last rising edge (still held on the pins).
    task automatic check_all(string req);
        int sum = 0;
        for (int t = 0; t < NT; t++) begin
            int el = exp_lim(mode_i, int'(total_i), int'(thresh_i), active_i, t);
            int oc = int'(occ_i[t*CW +: CW]);
            int ef = (oc >= el) ? 0 : el - oc;
            sum += oc;
            chk(int'(limit_o[t*CW +: CW]) == el, {req, " limit (R12)"}, int'(limit_o[t*CW +: CW]), el);
            chk(int'(free_o[t*CW +: CW]) == ef, "R10 free", int'(free_o[t*CW +: CW]), ef);
        end
        chk(mode_err_o == (mode_i == 2'd3), "R8 err", int'(mode_err_o), int'(mode_i == 2'd3));
        begin
            int et = (sum >= int'(total_i)) ? 0 : int'(total_i) - sum;
            chk(int'(total_free_o) == et, "R11 total free", int'(total_free_o), et);
        end
    endtask

    task automatic apply(logic [1:0] m, int tot, int thr, logic [NT-1:0] a,
                         logic [NT*CW-1:0] oc, string req);
        mode_i = m; total_i = CW'(tot); thresh_i = CW'(thr);
        active_i = a; occ_i = oc;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset holds everything at zero, even with the bad mode applied
        mode_i = 2'd3; total_i = 8'd50;
        repeat (3) @(negedge clk);
        chk(limit_o == '0, "R1 reset limits", int'(limit_o[CW-1:0]), 0);
        chk(mode_err_o == 1'b0, "R1 reset err", int'(mode_err_o), 0);
        mode_i = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(limit_o == '0, "R1 after release", int'(limit_o[CW-1:0]), 0);
        @(negedge clk);
        check_all("R2");

        // R2 shared
        apply(2'd0, 10, 3, 4'b1111, {8'd2, 8'd0, 8'd12, 8'd5}, "R2");
        // R9: change total, output holds until the edge
        total_i = 8'd20;
        #1;
        chk(int'(limit_o[CW-1:0]) == 10, "R9 hold before edge", int'(limit_o[CW-1:0]), 10);
        @(negedge clk);
        chk(int'(limit_o[CW-1:0]) == 20, "R9 update after edge", int'(limit_o[CW-1:0]), 20);
        // R3 split, all active, remainder dropped: 10/4 = 2
        apply(2'd1, 10, 0, 4'b1111, {8'd1, 8'd2, 8'd3, 8'd0}, "R3");
        // R4 two active: 5 for threads 0 and 2, 2 for the others
        apply(2'd1, 10, 0, 4'b0101, {8'd0, 8'd9, 8'd0, 8'd4}, "R4");
        // R4 three active: 10/3 = 3
        apply(2'd1, 10, 0, 4'b1110, '0, "R4");
        // R5 none active
        apply(2'd1, 11, 0, 4'b0000, '0, "R5");
        // R6 capped with several active
        apply(2'd2, 40, 7, 4'b0011, {8'd0, 8'd0, 8'd9, 8'd3}, "R6");
        // R7 lone thread gets the whole buffer
        apply(2'd2, 40, 7, 4'b0100, {8'd0, 8'd30, 8'd0, 8'd0}, "R7");
        // R8 invalid mode
        apply(2'd3, 40, 7, 4'b1111, {8'd1, 8'd1, 8'd1, 8'd1}, "R8");
        // R10 ceiling lowered below occupancy; R11 sum above total
        apply(2'd1, 10, 0, 4'b1111, {8'd5, 8'd5, 8'd5, 8'd5}, "R10");
        apply(2'd0, 255, 0, 4'b1111, {8'd255, 8'd255, 8'd0, 8'd0}, "R11");

        for (int i = 0; i < 400; i++) begin
            logic [NT*CW-1:0] oc;
            for (int t = 0; t < NT; t++) oc[t*CW +: CW] = CW'($urandom % 90);
            apply(2'($urandom % 4), int'($urandom % 256), int'($urandom % 256),
                  NT'($urandom), oc, "R2/R4/R7 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule